// File: doc/BRIEF.md
# Triple-Port Buffer Host-Port Access Controller

This block controls the wide, bidirectional host port of a buffer that has two FIFOs and three ports. Each rising clock edge it decodes a low-active chip select, a write/read direction select, an enable, a mailbox select and a low-active loopback control. From these it produces the write side of FIFO1, the read side of FIFO2, accesses to two single-word mailbox registers, and the output-enable that the pad ring uses to drive the shared data bus. The pad ring builds the tri-state bus from `pa_din`, `pa_dout` and `pa_oe`.

FIFO1 write and FIFO2 read are valid/ready interfaces. A word moves only on an edge where valid and ready are both high. `f1_wvalid` and `f2_rready` are decoded from the port controls and do not depend on the ready or valid they are paired with. The one exception is loopback: there each side is qualified by the other FIFO's flag, so a word leaves FIFO2 only on an edge where FIFO1 accepts it. While FIFO1 holds `f1_wready` low, the port keeps `f1_wvalid` and `f1_wdata` steady for as long as the command is held. The FIFO memories and the other two ports' controllers are outside this block. Port A activity never waits on them.

Top module: `porta_ctrl`

## Requirements
- R1: `pa_oe` is high only when `rst_n` is high, `sel_n` is low and `dir_wr` is low. Otherwise it is low (bus at high impedance).
- R2: With `sel_n`=0, `dir_wr`=1, `en`=1, `mbx_sel`=0 and `loop_n`=1, `f1_wvalid` is high and `f1_wdata` equals `pa_din`. The word is written on an edge where `f1_wready` is high.
- R3: With `sel_n`=0, `dir_wr`=0, `en`=1, `mbx_sel`=0 and `loop_n`=1, `f2_rready` is high. On an edge where `f2_rvalid` is high, `pa_dout` takes `f2_rdata` after that edge. If `f2_rvalid` is low, `pa_dout` keeps its previous word.
- R4: A write command with `mbx_sel`=1 and `mb1_empty`=1 loads `pa_din` into `mb1_data` and drives `mb1_empty` low after the edge. `f1_wvalid` stays low.
- R5: While `mb1_empty` is low, further mailbox-1 writes are ignored. `mb1_rd`=1 on an edge sets `mb1_empty` high again.
- R6: `mb2_wr`=1 with `mb2_empty`=1 loads `mb2_wdata` and drives `mb2_empty` low. A read command with `mbx_sel`=1 then puts that word on `pa_dout` after the edge and sets `mb2_empty` high. `f2_rready` stays low during this read.
- R7: With `sel_n`=0, `en`=1, `mbx_sel`=0, `loop_n`=0 and `dir_wr`=1, `f1_wdata` equals `f2_rdata` and the bus stays at high impedance. `pa_dout` is unchanged.
- R8: The same loopback with `dir_wr`=0 also drives the bus. After a transfer edge, `pa_dout` equals the transferred word.
- R9: A loopback transfer is suppressed when FIFO2 is empty or FIFO1 is full. `f1_wvalid` is low while `f2_rvalid` is low, and `f2_rready` is low while `f1_wready` is low. `pa_dout` is unchanged.
- R10: While `rst_n` is low, `pa_oe`, `f1_wvalid` and `f2_rready` are low and all control inputs are ignored. Reset leaves `pa_dout` at 0 and both mailbox flags high (empty).
- R11: With `en`=0, no FIFO or mailbox operation occurs and `pa_dout` is unchanged. `pa_oe` still follows R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_n | input | 1 | Port chip select, active low |
| dir_wr | input | 1 | 1 = write into the buffer, 0 = read from it |
| en | input | 1 | Operation enable |
| mbx_sel | input | 1 | 1 = mailbox access instead of FIFO |
| loop_n | input | 1 | 0 = move FIFO2 output into FIFO1 |
| pa_din | input | W | Bus value seen at the pads |
| pa_dout | output | W | Registered word for the bus |
| pa_oe | output | 1 | Bus output-enable |
| f1_wdata | output | W | FIFO1 write data |
| f1_wvalid | output | 1 | FIFO1 write valid |
| f1_wready | input | 1 | FIFO1 not full (input ready) |
| f2_rdata | input | W | FIFO2 head word |
| f2_rvalid | input | 1 | FIFO2 not empty (output ready) |
| f2_rready | output | 1 | FIFO2 read strobe |
| mb1_rd | input | 1 | Other port reads mailbox 1 |
| mb1_data | output | W | Mailbox-1 contents |
| mb1_empty | output | 1 | Mailbox-1 flag, 0 = full |
| mb2_wr | input | 1 | Other port writes mailbox 2 |
| mb2_wdata | input | W | Mailbox-2 write data |
| mb2_empty | output | 1 | Mailbox-2 flag, 0 = full |

## Verification
A decode fault shows in the same cycle as a wrong `f1_wvalid`, `f2_rready` or `pa_oe`, before the edge where it would move data. A fault in the output register or a mailbox shows one edge after the command, as a wrong `pa_dout`, `mb1_data` or flag. A lost word in loopback shows as a strobe on one FIFO without the matching strobe on the other in the same cycle. The directed tests sample at each of these points.

// File: rtl/porta_pkg.sv
package porta_pkg;

  typedef enum logic [2:0] {
    OP_IDLE       = 3'd0,
    OP_F1_WR      = 3'd1,
    OP_F2_RD      = 3'd2,
    OP_MB1_WR     = 3'd3,
    OP_MB2_RD     = 3'd4,
    OP_LOOP_QUIET = 3'd5,
    OP_LOOP_BUS   = 3'd6
  } porta_op_e;

endpackage

// File: rtl/porta_decode.sv
module porta_decode
  import porta_pkg::*;
(
  input  logic      rst_n,
  input  logic      sel_n,
  input  logic      dir_wr,
  input  logic      en,
  input  logic      mbx_sel,
  input  logic      loop_n,
  output porta_op_e op,
  output logic      drive_bus
);

  // Bus direction depends only on select and direction, never on enable.
  assign drive_bus = rst_n && !sel_n && !dir_wr;

  always_comb begin
    op = OP_IDLE;
    if (rst_n && !sel_n && en) begin
      if (!loop_n) begin
        if (!mbx_sel) op = dir_wr ? OP_LOOP_QUIET : OP_LOOP_BUS;
      end else if (dir_wr) begin
        op = mbx_sel ? OP_MB1_WR : OP_F1_WR;
      end else begin
        op = mbx_sel ? OP_MB2_RD : OP_F2_RD;
      end
    end
  end

endmodule

// File: rtl/porta_mailbox.sv
module porta_mailbox #(
  parameter int W = 36
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty
);

  logic load, drain;
  assign load  = wr_en && empty;
  assign drain = rd_en && !empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      empty   <= 1'b1;
    end else begin
      if (load) rd_data <= wr_data;
      if (load)       empty <= 1'b0;
      else if (drain) empty <= 1'b1;
    end
  end

  AST_MBX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && empty) |=> (!empty && rd_data == $past(wr_data))); // R4

  AST_MBX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !rd_en) |=> (!empty && $stable(rd_data))); // R5

endmodule

// File: rtl/porta_outreg.sv
module porta_outreg #(
  parameter int W = 36
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= load_data;
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q)); // R11

endmodule

// File: rtl/porta_ctrl.sv
module porta_ctrl
  import porta_pkg::*;
#(
  parameter int W = 36
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel_n,
  input  logic         dir_wr,
  input  logic         en,
  input  logic         mbx_sel,
  input  logic         loop_n,
  input  logic [W-1:0] pa_din,
  output logic [W-1:0] pa_dout,
  output logic         pa_oe,
  output logic [W-1:0] f1_wdata,
  output logic         f1_wvalid,
  input  logic         f1_wready,
  input  logic [W-1:0] f2_rdata,
  input  logic         f2_rvalid,
  output logic         f2_rready,
  input  logic         mb1_rd,
  output logic [W-1:0] mb1_data,
  output logic         mb1_empty,
  input  logic         mb2_wr,
  input  logic [W-1:0] mb2_wdata,
  output logic         mb2_empty
);

  porta_op_e    op;
  logic         is_loop;
  logic         out_load;
  logic [W-1:0] out_data;
  logic [W-1:0] mb2_q;

  porta_decode u_dec (
    .rst_n     (rst_n),
    .sel_n     (sel_n),
    .dir_wr    (dir_wr),
    .en        (en),
    .mbx_sel   (mbx_sel),
    .loop_n    (loop_n),
    .op        (op),
    .drive_bus (pa_oe)
  );

  assign is_loop = (op == OP_LOOP_QUIET) || (op == OP_LOOP_BUS);

  // Loopback pairs the two handshakes: each side waits on the other FIFO's flag.
  assign f1_wvalid = (op == OP_F1_WR) || (is_loop && f2_rvalid);
  assign f1_wdata  = is_loop ? f2_rdata : pa_din;
  assign f2_rready = (op == OP_F2_RD) || (is_loop && f1_wready);

  always_comb begin
    out_load = 1'b0;
    out_data = f2_rdata;
    unique case (op)
      OP_F2_RD:    out_load = f2_rvalid;
      OP_LOOP_BUS: out_load = f2_rvalid && f1_wready;
      OP_MB2_RD: begin
        out_load = !mb2_empty;
        out_data = mb2_q;
      end
      default:     out_load = 1'b0;
    endcase
  end

  porta_outreg #(.W(W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (out_load),
    .load_data (out_data),
    .q         (pa_dout)
  );

  porta_mailbox #(.W(W)) u_mb1 (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (op == OP_MB1_WR),
    .wr_data (pa_din),
    .rd_en   (mb1_rd),
    .rd_data (mb1_data),
    .empty   (mb1_empty)
  );

  porta_mailbox #(.W(W)) u_mb2 (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (mb2_wr),
    .wr_data (mb2_wdata),
    .rd_en   (op == OP_MB2_RD),
    .rd_data (mb2_q),
    .empty   (mb2_empty)
  );

  always_comb begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!pa_oe && !f1_wvalid && !f2_rready); // R10
    end
  end

  AST_RD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_F2_RD && f2_rvalid) |=> (pa_dout == $past(f2_rdata))); // R3

  AST_MB2_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_MB2_RD && !mb2_empty) |=> mb2_empty); // R6

  AST_LOOP_QUIET_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_LOOP_QUIET) |-> !pa_oe); // R7

  AST_LOOP_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    (is_loop && f2_rready && f2_rvalid) |-> (f1_wvalid && f1_wready)); // R9

endmodule

// File: tb/tb_porta_ctrl.sv
module tb_porta_ctrl;

  localparam int W     = 36;
  localparam int CLK_P = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sel_n = 1'b1, dir_wr = 1'b0, en = 1'b0, mbx_sel = 1'b0, loop_n = 1'b1;
  logic [W-1:0] pa_din = '0;
  logic [W-1:0] pa_dout;
  logic         pa_oe;
  logic [W-1:0] f1_wdata;
  logic         f1_wvalid;
  logic         f1_wready = 1'b0;
  logic [W-1:0] f2_rdata = '0;
  logic         f2_rvalid = 1'b0;
  logic         f2_rready;
  logic         mb1_rd = 1'b0;
  logic [W-1:0] mb1_data;
  logic         mb1_empty;
  logic         mb2_wr = 1'b0;
  logic [W-1:0] mb2_wdata = '0;
  logic         mb2_empty;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] last_out;

  always #(CLK_P/2) clk = ~clk;

  porta_ctrl #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .dir_wr(dir_wr), .en(en),
    .mbx_sel(mbx_sel), .loop_n(loop_n), .pa_din(pa_din), .pa_dout(pa_dout),
    .pa_oe(pa_oe), .f1_wdata(f1_wdata), .f1_wvalid(f1_wvalid),
    .f1_wready(f1_wready), .f2_rdata(f2_rdata), .f2_rvalid(f2_rvalid),
    .f2_rready(f2_rready), .mb1_rd(mb1_rd), .mb1_data(mb1_data),
    .mb1_empty(mb1_empty), .mb2_wr(mb2_wr), .mb2_wdata(mb2_wdata),
    .mb2_empty(mb2_empty)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    sel_n = 1'b1; dir_wr = 1'b0; en = 1'b0; mbx_sel = 1'b0; loop_n = 1'b1;
    mb1_rd = 1'b0; mb2_wr = 1'b0;
  endtask

  task automatic cmd(input logic s_n, input logic d, input logic e, input logic m, input logic l_n);
    sel_n = s_n; dir_wr = d; en = e; mbx_sel = m; loop_n = l_n;
  endtask

  // Inputs change at the falling edge; combinational outputs sampled 1 time unit later.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cmd(1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    f2_rvalid = 1'b1; f1_wready = 1'b1; f2_rdata = 36'h0_DEAD_BEEF;
    #1;
    check("R10 oe in reset", pa_oe, 0);
    check("R10 f2_rready in reset", f2_rready, 0);
    cmd(1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    #1;
    check("R10 f1_wvalid in reset", f1_wvalid, 0);
    step();
    check("R10 dout reset", pa_dout, 0);
    check("R10 mb1 flag", mb1_empty, 1);
    check("R10 mb2 flag", mb2_empty, 1);
    idle();
    rst_n = 1'b1;
    f2_rvalid = 1'b0; f1_wready = 1'b0;
    step();
    last_out = '0;
  endtask

  task automatic t_bus_oe();
    cmd(1'b1, 1'b0, 1'b1, 1'b0, 1'b1); #1;
    check("R1 oe sel_n high", pa_oe, 0);
    cmd(1'b0, 1'b1, 1'b1, 1'b0, 1'b1); #1;
    check("R1 oe dir_wr high", pa_oe, 0);
    cmd(1'b0, 1'b0, 1'b0, 1'b0, 1'b1); #1;
    check("R1 oe both low", pa_oe, 1);
    idle(); step();
  endtask

  task automatic t_fifo1_write();
    cmd(1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    pa_din = 36'h1_2345_6789; f1_wready = 1'b0; #1;
    check("R2 wvalid under backpressure", f1_wvalid, 1);
    check("R2 wdata", f1_wdata, 36'h1_2345_6789);
    check("R2 no fifo2 read", f2_rready, 0);
    step();
    f1_wready = 1'b1; #1;
    check("R2 wvalid held", f1_wvalid, 1);
    step();
    idle(); f1_wready = 1'b0; step();
  endtask

  task automatic t_fifo2_read();
    cmd(1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    f2_rvalid = 1'b1; f2_rdata = 36'hA_0000_0001; #1;
    check("R3 rready", f2_rready, 1);
    check("R3 no f1 write", f1_wvalid, 0);
    step();
    check("R3 dout captured", pa_dout, 36'hA_0000_0001);
    f2_rvalid = 1'b0; f2_rdata = 36'hB_0000_0002;
    step();
    check("R3 dout held when empty", pa_dout, 36'hA_0000_0001);
    last_out = 36'hA_0000_0001;
    idle(); step();
  endtask

  task automatic t_mbox1();
    cmd(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    pa_din = 36'h5_5555_AAAA; f1_wready = 1'b1; #1;
    check("R4 no fifo1 write on mailbox", f1_wvalid, 0);
    step();
    check("R4 mb1 flag full", mb1_empty, 0);
    check("R4 mb1 data", mb1_data, 36'h5_5555_AAAA);
    pa_din = 36'h0_0000_1111;
    step();
    check("R5 full mailbox ignores write", mb1_data, 36'h5_5555_AAAA);
    idle(); f1_wready = 1'b0; mb1_rd = 1'b1;
    step();
    check("R5 read empties mb1", mb1_empty, 1);
    idle(); step();
  endtask

  task automatic t_mbox2();
    mb2_wr = 1'b1; mb2_wdata = 36'hC_CAFE_0042;
    step();
    mb2_wr = 1'b0;
    check("R6 mb2 flag full", mb2_empty, 0);
    cmd(1'b0, 1'b0, 1'b1, 1'b1, 1'b1); f2_rvalid = 1'b1; #1;
    check("R6 no fifo2 read on mailbox", f2_rready, 0);
    step();
    check("R6 mb2 word on bus", pa_dout, 36'hC_CAFE_0042);
    check("R6 mb2 flag empty", mb2_empty, 1);
    last_out = 36'hC_CAFE_0042;
    idle(); f2_rvalid = 1'b0; step();
  endtask

  task automatic t_loop_quiet();
    cmd(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    f2_rvalid = 1'b1; f1_wready = 1'b1; f2_rdata = 36'h7_0707_0707; pa_din = '0; #1;
    check("R7 wvalid", f1_wvalid, 1);
    check("R7 wdata from fifo2", f1_wdata, 36'h7_0707_0707);
    check("R7 rready", f2_rready, 1);
    check("R7 bus hiz", pa_oe, 0);
    step();
    check("R7 dout unchanged", pa_dout, last_out);
    idle(); step();
  endtask

  task automatic t_loop_bus();
    cmd(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    f2_rvalid = 1'b1; f1_wready = 1'b1; f2_rdata = 36'h8_1234_8888; #1;
    check("R8 bus driven", pa_oe, 1);
    check("R8 wvalid", f1_wvalid, 1);
    step();
    check("R8 dout word", pa_dout, 36'h8_1234_8888);
    last_out = 36'h8_1234_8888;
    idle(); step();
  endtask

  task automatic t_loop_suppress();
    cmd(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    f2_rvalid = 1'b0; f1_wready = 1'b1; f2_rdata = 36'h9_9999_0000; #1;
    check("R9 no wvalid when fifo2 empty", f1_wvalid, 0);
    step();
    f2_rvalid = 1'b1; f1_wready = 1'b0; #1;
    check("R9 no rready when fifo1 full", f2_rready, 0);
    step();
    check("R9 dout unchanged", pa_dout, last_out);
    idle(); f2_rvalid = 1'b0; step();
  endtask

  task automatic t_enable_low();
    cmd(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    f2_rvalid = 1'b1; f2_rdata = 36'hE_EEEE_EEEE; #1;
    check("R11 no rready when disabled", f2_rready, 0);
    check("R11 oe still follows select", pa_oe, 1);
    step();
    check("R11 dout unchanged", pa_dout, last_out);
    idle(); f2_rvalid = 1'b0; step();
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    last_out = '0;
    repeat (2) @(posedge clk);
    t_reset();
    t_bus_oe();
    t_fifo1_write();
    t_fifo2_read();
    t_mbox1();
    t_mbox2();
    t_loop_quiet();
    t_loop_bus();
    t_loop_suppress();
    t_enable_low();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule